// File: doc/BRIEF.md
# Dual-Class Interrupt Controller

This block gathers level-sensitive interrupt lines from on-chip peripherals and presents them to a processor as two request classes: a normal request and a fast request. Each source can be enabled on its own in either class. The two classes share a single bit layout. Bit 0 of every view is the logical OR of all the other bits. Bit 1 is a software interrupt, which firmware raises and lowers through its own register. Bits 2 and up carry the peripheral lines. Two positions, 15 and 17, are reserved.

Software reaches the block through a simple single-cycle register bus with word offsets. For each class there is a raw view of the source lines, a set-only enable register, a clear-only companion and a masked status word. A source-select register picks one source. A compact view of that source's state can then be read in one access. The peripherals hold their own lines high until they are serviced locally. The controller therefore stores no pending state of its own, apart from the enable masks and the software-interrupt bit.

Top module: `dual_intc`

## Requirements
- R1: After reset, every enable bit, the software-interrupt bit and the select register are 0, both request outputs are low, and all readable offsets return 0 while the source lines are low.
- R2: A write to offset 1 (normal class) or offset 5 (fast class) sets each enable bit whose data bit is 1. Data bits of 0 leave the enable unchanged, and a read of the same offset returns the current enable mask.
- R3: A write to offset 2 (normal) or offset 6 (fast) clears each enable bit whose data bit is 1 and leaves the others unchanged. These offsets read as 0.
- R4: Enable bits 0, 1, 15, 17 and all bits from 20 upward cannot be set. They always read 0, so a write of all ones to offset 1 reads back 0x000D7FFC.
- R5: The raw view at offset 0 (normal) and offset 4 (fast) shows source line k in bit k for every implemented position 2..19, whether or not that source is enabled. Bit 1 shows the software-interrupt bit, and reserved positions read 0.
- R6: Status bit k (2..19) at offset 3 (normal) or offset 7 (fast) is 1 only when source line k is high and enabled in that class. A high line that is not enabled sets no status bit and raises no request.
- R7: Bit 0 of every raw view and status word equals the OR of bits 1..19 of the same word.
- R8: A request output goes high on the first clock edge after any of bits 1..19 of its class status becomes 1. It goes low on the first clock edge after all of those bits are 0.
- R9: The two classes are independent: enabling a source in one class changes neither the enable mask, the status nor the request of the other class.
- R10: Writing data bit 0 = 1 to offset 8 sets the software-interrupt bit, and writing 0 clears it. The bit reads back at offset 8 bit 0. It is always enabled, so it appears as bit 1 of both raw views and both status words and raises both requests.
- R11: Offset 9 holds a source number. A write of a value below 20 stores it, and a write of 20 or more is ignored. Offset 10 returns, for the selected source: bit 0 raw line, bit 1 normal enable, bit 2 fast enable, bit 3 normal status, bit 4 fast status.
- R12: Offsets 11 to 15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read is active |
| src_i | input | 20 | Level-sensitive source lines; bits 0, 1, 15 and 17 are ignored |
| irq_o | output | 1 | Normal-class request, level-sensitive |
| fast_irq_o | output | 1 | Fast-class request, level-sensitive |

## Verification
The assertions check several rules on every cycle: that set and clear writes take effect on the next edge, that reserved enable positions stay zero, that no status bit is present without its enable, that bit 0 of every status read agrees with the rest of the word, that each request follows its status one edge later, and that the select register never holds an out-of-range number. The bench scenarios cover the rest. They show the raw view of unenabled sources, the independence of the two classes, the software interrupt reaching both classes at once, the contents of the selected-source view, the rejection of out-of-range selections, and that unmapped offsets are inert.

// File: rtl/dual_intc_pkg.sv
package dual_intc_pkg;

  localparam int MAX_W     = 32;
  localparam int ADDR_W    = 4;
  localparam int NUM_CLASS = 2;
  localparam int AGG_BIT   = 0;
  localparam int SWI_BIT   = 1;
  localparam int FIRST_SRC = 2;
  localparam int RSV_LO    = 15;
  localparam int RSV_HI    = 17;
  localparam int VIEW_W    = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFS_N_RAW  = 4'd0,
    OFS_N_SET  = 4'd1,
    OFS_N_CLR  = 4'd2,
    OFS_N_STAT = 4'd3,
    OFS_F_RAW  = 4'd4,
    OFS_F_SET  = 4'd5,
    OFS_F_CLR  = 4'd6,
    OFS_F_STAT = 4'd7,
    OFS_SWI    = 4'd8,
    OFS_SEL    = 4'd9,
    OFS_VIEW   = 4'd10
  } reg_ofs_e;

  // Positions that carry a real peripheral line.
  function automatic logic [MAX_W-1:0] src_mask(input int n);
    logic [MAX_W-1:0] m;
    for (int k = 0; k < MAX_W; k++) begin
      m[k] = (k >= FIRST_SRC) && (k < n) && (k != RSV_LO) && (k != RSV_HI);
    end
    return m;
  endfunction

endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/intc_class.sv
module intc_class
  import dual_intc_pkg::*;
#(
  parameter int NUM_SRC = 20
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               set_we,
  input  logic               clr_we,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] raw_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] stat_o,
  output logic               req_o
);

  localparam logic [MAX_W-1:0]   MASK_FULL = src_mask(NUM_SRC);
  localparam logic [NUM_SRC-1:0] MASK      = MASK_FULL[NUM_SRC-1:0];
  localparam logic [NUM_SRC-1:0] SWI_ONE   = NUM_SRC'(1) << SWI_BIT;
  localparam logic [NUM_SRC-1:0] AGG_ONE   = NUM_SRC'(1) << AGG_BIT;

  logic [NUM_SRC-1:0] en_q, en_d;
  logic [NUM_SRC-1:0] body;
  logic               req_q, req_d;

  always_comb begin
    en_d = en_q;
    if (set_we)      en_d = en_q | (wdata & MASK);
    else if (clr_we) en_d = en_q & ~(wdata & MASK);
  end

  always_comb begin
    body   = raw_i & (en_q | SWI_ONE) & ~AGG_ONE;
    stat_o = {body[NUM_SRC-1:1], |body[NUM_SRC-1:1]};
    req_d  = |body;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      req_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      req_q <= req_d;
    end
  end

  assign en_o  = en_q;
  assign req_o = req_q;

endmodule

// File: rtl/intc_regif.sv
module intc_regif
  import dual_intc_pkg::*;
#(
  parameter int NUM_SRC = 20,
  parameter int DATA_W  = 32,
  localparam int SEL_W  = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 bus_en,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [NUM_SRC-1:0]   src_i,
  input  logic [NUM_SRC-1:0]   n_en,
  input  logic [NUM_SRC-1:0]   f_en,
  input  logic [NUM_SRC-1:0]   n_stat,
  input  logic [NUM_SRC-1:0]   f_stat,
  output logic [NUM_SRC-1:0]   raw_o,
  output logic [NUM_CLASS-1:0] set_we_o,
  output logic [NUM_CLASS-1:0] clr_we_o,
  output logic                 swi_o,
  output logic [SEL_W-1:0]     sel_o,
  output logic [DATA_W-1:0]    bus_rdata
);

  localparam logic [MAX_W-1:0]   MASK_FULL = src_mask(NUM_SRC);
  localparam logic [NUM_SRC-1:0] MASK      = MASK_FULL[NUM_SRC-1:0];

  logic               wr_hit;
  logic               swi_q, swi_d;
  logic [SEL_W-1:0]   sel_q, sel_d;
  logic [NUM_SRC-1:0] raw_body;
  logic [VIEW_W-1:0]  view;
  logic [DATA_W-1:0]  rd_mux;
  logic               unused_src;

  assign wr_hit     = bus_en & bus_wr;
  assign unused_src = ^(src_i & ~MASK);

  // Raw view: peripheral lines where implemented, software bit at its slot.
  genvar k;
  for (k = 0; k < NUM_SRC; k++) begin : g_raw
    if (k == SWI_BIT) begin : g_swi
      assign raw_body[k] = swi_q;
    end else if (MASK[k]) begin : g_line
      assign raw_body[k] = src_i[k];
    end else begin : g_zero
      assign raw_body[k] = 1'b0;
    end
  end
  assign raw_o = {raw_body[NUM_SRC-1:1], |raw_body[NUM_SRC-1:1]};

  // Write strobes per class.
  always_comb begin
    set_we_o = '0;
    clr_we_o = '0;
    if (wr_hit) begin
      set_we_o[0] = (bus_addr == OFS_N_SET);
      set_we_o[1] = (bus_addr == OFS_F_SET);
      clr_we_o[0] = (bus_addr == OFS_N_CLR);
      clr_we_o[1] = (bus_addr == OFS_F_CLR);
    end
  end

  always_comb begin
    swi_d = swi_q;
    sel_d = sel_q;
    if (wr_hit && bus_addr == OFS_SWI) swi_d = bus_wdata[0];
    if (wr_hit && bus_addr == OFS_SEL && bus_wdata < DATA_W'(NUM_SRC))
      sel_d = bus_wdata[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      swi_q <= 1'b0;
      sel_q <= '0;
    end else begin
      swi_q <= swi_d;
      sel_q <= sel_d;
    end
  end

  assign view = {f_stat[sel_q], n_stat[sel_q], f_en[sel_q], n_en[sel_q], raw_o[sel_q]};

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_N_RAW,
      OFS_F_RAW:  rd_mux = DATA_W'(raw_o);
      OFS_N_SET:  rd_mux = DATA_W'(n_en);
      OFS_N_STAT: rd_mux = DATA_W'(n_stat);
      OFS_F_SET:  rd_mux = DATA_W'(f_en);
      OFS_F_STAT: rd_mux = DATA_W'(f_stat);
      OFS_SWI:    rd_mux = DATA_W'(swi_q);
      OFS_SEL:    rd_mux = DATA_W'(sel_q);
      OFS_VIEW:   rd_mux = DATA_W'(view);
      default:    rd_mux = '0;
    endcase
  end

  assign bus_rdata = (bus_en && !bus_wr) ? rd_mux : '0;
  assign swi_o     = swi_q;
  assign sel_o     = sel_q;

endmodule

// File: rtl/dual_intc.sv
module dual_intc
  import dual_intc_pkg::*;
#(
  parameter int NUM_SRC = 20,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] src_i,
  output logic              irq_o,
  output logic              fast_irq_o
);

  localparam int SEL_W = $clog2(NUM_SRC);

  logic                 rst_sync_n;
  logic [NUM_SRC-1:0]   raw_view;
  logic [NUM_CLASS-1:0] set_we, clr_we;
  logic [NUM_SRC-1:0]   en_all   [NUM_CLASS];
  logic [NUM_SRC-1:0]   stat_all [NUM_CLASS];
  logic [NUM_CLASS-1:0] req_all;
  logic [NUM_SRC-1:0]   n_en, f_en, n_stat, f_stat;
  logic                 swi_q;
  logic [SEL_W-1:0]     sel_q;

  intc_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  intc_regif #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regif (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .src_i     (src_i),
    .n_en      (n_en),
    .f_en      (f_en),
    .n_stat    (n_stat),
    .f_stat    (f_stat),
    .raw_o     (raw_view),
    .set_we_o  (set_we),
    .clr_we_o  (clr_we),
    .swi_o     (swi_q),
    .sel_o     (sel_q),
    .bus_rdata (bus_rdata)
  );

  genvar c;
  for (c = 0; c < NUM_CLASS; c++) begin : g_class
    intc_class #(.NUM_SRC(NUM_SRC)) u_class (
      .clk    (clk),
      .rst_ni (rst_sync_n),
      .set_we (set_we[c]),
      .clr_we (clr_we[c]),
      .wdata  (bus_wdata[NUM_SRC-1:0]),
      .raw_i  (raw_view),
      .en_o   (en_all[c]),
      .stat_o (stat_all[c]),
      .req_o  (req_all[c])
    );
  end

  assign n_en       = en_all[0];
  assign f_en       = en_all[1];
  assign n_stat     = stat_all[0];
  assign f_stat     = stat_all[1];
  assign irq_o      = req_all[0];
  assign fast_irq_o = req_all[1];

endmodule

// File: rtl/dual_intc_chk.sv
module dual_intc_chk
  import dual_intc_pkg::*;
#(
  parameter int NUM_SRC = 20,
  parameter int DATA_W  = 32,
  localparam int SEL_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_ni,
  input logic               bus_en,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_SRC-1:0] n_en,
  input logic [NUM_SRC-1:0] f_en,
  input logic [NUM_SRC-1:0] n_stat,
  input logic [NUM_SRC-1:0] f_stat,
  input logic               swi,
  input logic [SEL_W-1:0]   sel,
  input logic               irq_o,
  input logic               fast_irq_o
);

  localparam logic [MAX_W-1:0]   MASK_FULL = src_mask(NUM_SRC);
  localparam logic [NUM_SRC-1:0] MASK      = MASK_FULL[NUM_SRC-1:0];

  logic [NUM_SRC-1:0] wd;
  assign wd = bus_wdata[NUM_SRC-1:0];

  AST_NSET_TAKES: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_en && bus_wr && bus_addr == OFS_N_SET) |=> ((n_en & $past(wd) & MASK) == ($past(wd) & MASK))); // R2
  AST_FSET_TAKES: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_en && bus_wr && bus_addr == OFS_F_SET) |=> ((f_en & $past(wd) & MASK) == ($past(wd) & MASK))); // R2
  AST_NCLR_TAKES: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_en && bus_wr && bus_addr == OFS_N_CLR) |=> ((n_en & $past(wd)) == '0)); // R3
  AST_FCLR_TAKES: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_en && bus_wr && bus_addr == OFS_F_CLR) |=> ((f_en & $past(wd)) == '0)); // R3
  AST_EN_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    ((n_en | f_en) & ~MASK) == '0); // R4
  AST_STAT_GATED: assert property (@(posedge clk) disable iff (!rst_ni)
    (((n_stat & ~n_en) | (f_stat & ~f_en)) >> FIRST_SRC) == '0); // R6
  AST_AGG_READ: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_en && !bus_wr && (bus_addr == OFS_N_STAT || bus_addr == OFS_F_STAT))
      |-> (bus_rdata[0] == |bus_rdata[NUM_SRC-1:1])); // R7
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_ni)
    (|n_stat[NUM_SRC-1:1]) |=> irq_o); // R8
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_ni)
    !(|n_stat[NUM_SRC-1:1]) |=> !irq_o); // R8
  AST_FIQ_RISE: assert property (@(posedge clk) disable iff (!rst_ni)
    (|f_stat[NUM_SRC-1:1]) |=> fast_irq_o); // R8
  AST_FIQ_DROP: assert property (@(posedge clk) disable iff (!rst_ni)
    !(|f_stat[NUM_SRC-1:1]) |=> !fast_irq_o); // R8
  AST_SWI_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_en && bus_wr && bus_addr == OFS_SWI) |=> (swi == $past(bus_wdata[0]))); // R10
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    int'(sel) < NUM_SRC); // R11

endmodule

bind dual_intc dual_intc_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .bus_en     (bus_en),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .n_en       (n_en),
  .f_en       (f_en),
  .n_stat     (n_stat),
  .f_stat     (f_stat),
  .swi        (swi_q),
  .sel        (sel_q),
  .irq_o      (irq_o),
  .fast_irq_o (fast_irq_o)
);

// File: tb/dual_intc_test.sv
module dual_intc_test;

  logic        clk;
  logic        rst_n;
  logic        bus_en, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [19:0] src_i;
  logic        irq_o, fast_irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  localparam logic [31:0] IMPL = 32'h000D_7FFC; // R4 implemented enable positions

  dual_intc uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_i(src_i), .irq_o(irq_o), .fast_irq_o(fast_irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic drive_src(input logic [19:0] v);
    @(negedge clk);
    src_i = v;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 16; a++) rd_chk("R1 reg after reset", 4'(a), 32'h0);
    chk("R1 irq_o after reset", {31'b0, irq_o}, 32'h0);
    chk("R1 fast_irq_o after reset", {31'b0, fast_irq_o}, 32'h0);
  endtask

  task automatic t_set_clear;
    wr(4'd1, 32'h0000_0F0C);
    rd_chk("R2 normal enable set", 4'd1, 32'h0000_0F0C);
    wr(4'd1, 32'h0);
    rd_chk("R2 zero write keeps enable", 4'd1, 32'h0000_0F0C);
    wr(4'd2, 32'h0000_0104);
    rd_chk("R3 normal enable clear", 4'd1, 32'h0000_0E08);
    rd_chk("R3 clear offset reads 0", 4'd2, 32'h0);
    rd_chk("R9 fast enable untouched", 4'd5, 32'h0);
    wr(4'd5, 32'h0008_0000);
    rd_chk("R2 fast enable set", 4'd5, 32'h0008_0000);
    rd_chk("R9 normal enable untouched", 4'd1, 32'h0000_0E08);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd2, 32'hFFFF_FFFF);
    rd_chk("R3 fast clear all", 4'd5, 32'h0);
    rd_chk("R3 normal clear all", 4'd1, 32'h0);
  endtask

  task automatic t_reserved;
    wr(4'd1, 32'hFFFF_FFFF);
    rd_chk("R4 normal all-ones enable", 4'd1, IMPL);
    wr(4'd5, 32'h0002_8003);
    rd_chk("R4 fast reserved enable", 4'd5, 32'h0);
    wr(4'd2, 32'hFFFF_FFFF);
    rd_chk("R4 normal cleared", 4'd1, 32'h0);
  endtask

  task automatic t_raw;
    drive_src(20'hFFFFF);
    rd_chk("R5 normal raw all lines", 4'd0, IMPL | 32'h1);
    rd_chk("R5 fast raw all lines", 4'd4, IMPL | 32'h1);
    rd_chk("R6 normal stat without enable", 4'd3, 32'h0);
    rd_chk("R6 fast stat without enable", 4'd7, 32'h0);
    chk("R6 no irq without enable", {31'b0, irq_o}, 32'h0);
    drive_src(20'h2_8003);
    rd_chk("R5 reserved lines ignored", 4'd0, 32'h0);
    drive_src(20'h0);
    rd_chk("R7 raw zero word", 4'd0, 32'h0);
  endtask

  task automatic t_status;
    wr(4'd1, 32'h0000_1000);
    @(negedge clk);
    src_i = 20'h0_1000;
    #1 chk("R8 irq not yet high", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R8 irq high one edge later", {31'b0, irq_o}, 32'h1);
    chk("R9 fast stays low", {31'b0, fast_irq_o}, 32'h0);
    rd_chk("R6 normal stat bit 12", 4'd3, 32'h0000_1001);
    rd_chk("R9 fast stat empty", 4'd7, 32'h0);
    wr(4'd5, 32'h0008_0000);
    drive_src(20'h8_1000);
    @(negedge clk);
    chk("R8 fast high", {31'b0, fast_irq_o}, 32'h1);
    rd_chk("R7 fast stat bit 19 and agg", 4'd7, 32'h0008_0001);
    rd_chk("R6 normal stat ignores 19", 4'd3, 32'h0000_1001);
    @(negedge clk);
    src_i = 20'h0;
    #1 chk("R8 irq still high same cycle", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    chk("R8 irq low one edge later", {31'b0, irq_o}, 32'h0);
    chk("R8 fast low", {31'b0, fast_irq_o}, 32'h0);
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd6, 32'hFFFF_FFFF);
  endtask

  task automatic t_swi;
    wr(4'd8, 32'h1);
    rd_chk("R10 swi reads back", 4'd8, 32'h1);
    rd_chk("R10 swi in raw", 4'd0, 32'h3);
    rd_chk("R10 swi in normal stat", 4'd3, 32'h3);
    rd_chk("R10 swi in fast stat", 4'd7, 32'h3);
    chk("R10 swi raises irq", {31'b0, irq_o}, 32'h1);
    chk("R10 swi raises fast", {31'b0, fast_irq_o}, 32'h1);
    wr(4'd1, 32'h2);
    rd_chk("R4 swi enable bit absent", 4'd1, 32'h0);
    wr(4'd8, 32'h0);
    @(negedge clk);
    rd_chk("R10 swi cleared", 4'd8, 32'h0);
    chk("R10 irq low after swi clear", {31'b0, irq_o}, 32'h0);
    chk("R10 fast low after swi clear", {31'b0, fast_irq_o}, 32'h0);
  endtask

  task automatic t_sel;
    wr(4'd9, 32'd12);
    wr(4'd1, 32'h0000_1000);
    drive_src(20'h0_1000);
    rd_chk("R11 sel stored", 4'd9, 32'd12);
    rd_chk("R11 view of 12", 4'd10, 32'h0000_000B);
    wr(4'd9, 32'd25);
    rd_chk("R11 sel out of range ignored", 4'd9, 32'd12);
    wr(4'd9, 32'd20);
    rd_chk("R11 sel 20 ignored", 4'd9, 32'd12);
    wr(4'd9, 32'd19);
    wr(4'd5, 32'h0008_0000);
    drive_src(20'h8_0000);
    rd_chk("R11 view of 19", 4'd10, 32'h0000_0015);
    drive_src(20'h0);
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd6, 32'hFFFF_FFFF);
  endtask

  task automatic t_unmapped;
    wr(4'd1, 32'h0000_0030);
    for (int a = 11; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF);
    for (int a = 11; a < 16; a++) rd_chk("R12 unmapped reads 0", 4'(a), 32'h0);
    rd_chk("R12 normal enable unchanged", 4'd1, 32'h0000_0030);
    rd_chk("R12 fast enable unchanged", 4'd5, 32'h0);
    rd_chk("R12 swi unchanged", 4'd8, 32'h0);
    rd_chk("R12 sel unchanged", 4'd9, 32'd19);
  endtask

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; src_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_set_clear();
    t_reserved();
    t_raw();
    t_status();
    t_swi();
    t_sel();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule